// File: doc/BRIEF.md
# Multi-Format Serial Shifter with Transmit Pin Release Control

This block is a master-side synchronous serial shifter. It takes a parallel word of 4 to 32 bits through a valid/ready handshake and shifts it out MSB first. It generates the serial clock and the frame or select pin, samples the receive line, and returns the received word with a one-cycle strobe. Three framings are supported. The first is a pulse-framed stream, in which a one-clock frame pulse precedes the MSB. The second is SPI, with an active-low select held for the whole word. The third is a command/response exchange, in which the select stays low across an outgoing command, one turnaround clock and an incoming response of the same length.

The data pin is described by a value and a separate output-enable for the pad. With the release option off, the pin is driven at all times. With it on, each framing has its own rule for when the pin is driven. SPI drives the pin only while the select is low, and a configurable end level fills the gap after the last falling clock edge. The command/response framing drives the pin from the MSB and lets go just after the rising edge that samples the LSB. The pulse framing drives the pin for the data bits, and can optionally hold it for one extra clock edge after the LSB.

The serial clock runs at the system clock divided by 2*HALF_DIV. Every pin changes on a system clock edge. The configuration inputs are static, and the block captures them when a word is accepted.

Top module: `mfs_shifter`

## Requirements
- R1: `tx_ready` is 1 while no frame is in progress. A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle `tx_ready` is 0 until the frame ends. Data and configuration are captured at acceptance.
- R2: Time is counted in slots of HALF_DIV system cycles, and slot 0 starts in the cycle after acceptance. `sclk_o` is 0 when idle and changes only at the start of a slot. Let N be the word length. `word_len` below 4 gives N=4, and `word_len` above MAX_BITS gives N=MAX_BITS. Bits go out MSB first.
- R3: Pulse framing (`fmt`=0, and also 3) lasts 2N+3 slots. `sclk_o` is 1 in even slots. `frm_o` is 1 in slots 0 and 1 and otherwise 0, including when idle. Bit k (k=0 is the MSB) is on `txd_o` in slots 2k+2 and 2k+3. The LSB is held in slot 2N+2, and `txd_o` is 0 in slots 0 and 1.
- R4: SPI (`fmt`=1) lasts 2N+1 slots. `frm_o` (the select) is 0 throughout the frame and 1 when idle. `sclk_o` is 1 in odd slots. Bit k is on `txd_o` in slots 2k and 2k+1, and `txd_o` equals `end_level` in slot 2N.
- R5: Command/response (`fmt`=2) lasts 4N+2 slots. The select is 0 throughout and `sclk_o` is 1 in odd slots. Bit k is on `txd_o` in slots 2k and 2k+1, and `txd_o` is 0 from slot 2N on.
- R6: With `tx_hiz_en`=0, `txd_oe` is always 1. With `tx_hiz_en`=1 and no frame in progress, `txd_oe` is 0.
- R7: SPI with release on: `txd_oe` is 1 exactly while the select is 0. `last_hiz` has no effect in SPI.
- R8: Command/response with release on: `txd_oe` is 1 from the first cycle of slot 0 through the first system cycle of slot 2N-1, the rising edge that samples the LSB. It is 0 for the rest of the frame.
- R9: Pulse framing with release on: `txd_oe` is 1 in slots 2 to 2N+1. It is also 1 in slot 2N+2 when `last_hiz`=1, and it is 0 in every other slot.
- R10: `rxd_i` is sampled at the end of certain slots, and the first bit sampled is the MSB. SPI samples at the end of slots 0,2,…,2N-2. Pulse framing samples at the end of slots 2,4,…,2N. Command/response samples at the end of slots 2N+2,…,4N. In the cycle after the last slot, `rx_valid` is 1 for one cycle, and `rx_data` holds the N bits in its low bits with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Word offered |
| tx_data | input | MAX_BITS | Word to send, right-aligned |
| tx_ready | output | 1 | Block idle, word can be taken |
| fmt | input | 2 | 0 pulse framing, 1 SPI, 2 command/response, 3 as 0 |
| word_len | input | $clog2(MAX_BITS+1) | Bits per word, clamped to 4..MAX_BITS |
| tx_hiz_en | input | 1 | Enables releasing the data pin |
| last_hiz | input | 1 | Pulse framing: hold the pin one more edge after the LSB |
| end_level | input | 1 | SPI: level in the gap after the last falling edge |
| sclk_o | output | 1 | Serial clock |
| frm_o | output | 1 | Frame pulse or active-low select |
| txd_o | output | 1 | Transmit data value |
| txd_oe | output | 1 | Transmit pad output-enable |
| rxd_i | input | 1 | Receive data |
| rx_valid | output | 1 | One-cycle received-word strobe |
| rx_data | output | MAX_BITS | Received word, right-aligned |

## Verification
The end of one frame and the start of the next can fall into neighbouring cycles. In the cycle where `rx_valid` pulses, `tx_ready` has just risen, so a word that is already waiting is accepted on that same edge. The bench provokes this by holding `tx_valid` high with a new word across the end of an SPI frame. It then checks three things: the first word's `rx_data` and strobe in that cycle, the new select and MSB in the very next slot, and no stale bit from the first word on `txd_o`. The same per-cycle reference model also checks each framing's pin-release edge for word sizes 4, 8, 17 and 32.

// File: rtl/mfs_pkg.sv
// Shared types for the multi-format serial shifter.
// Assumes word lengths never exceed 255 (nbits field width).
package mfs_pkg;
    typedef enum logic [1:0] {
        FMT_PULSE  = 2'd0,
        FMT_SPI    = 2'd1,
        FMT_CMDRSP = 2'd2,
        FMT_RSVD   = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [7:0] nbits;
        logic       hiz_en;
        logic       tail_hiz;
        logic       end_lvl;
    } cfg_t;
endpackage

// File: rtl/mfs_tick.sv
// Slot timer: counts system cycles within one half serial clock.
// Assumes HALF_DIV >= 2; the counter sits at zero while idle.
module mfs_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step,
    output logic first
);
    localparam int SUB_W = $clog2(HALF_DIV);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(HALF_DIV - 1);

    logic [SUB_W-1:0] sub;

    // Advance the sub-slot counter while a frame runs, wrap at slot end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || sub == SUB_LAST) sub <= '0;
        else                                   sub <= sub + 1'b1;
    end

    assign step  = run && (sub == SUB_LAST);
    assign first = (sub == '0);
endmodule

// File: rtl/mfs_seq.sv
// Frame sequencer: slot counter, transmit and receive shift registers.
// Assumes start only arrives while idle and step only while busy.
module mfs_seq
    import mfs_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int SLOT_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  cfg_t                start_cfg,
    input  logic [MAX_BITS-1:0] start_data,
    input  logic                step,
    input  logic                rxd,
    output logic                busy,
    output cfg_t                cfg_q,
    output logic [SLOT_W-1:0]   slot,
    output logic                tx_bit,
    output logic                rx_valid,
    output logic [MAX_BITS-1:0] rx_data
);
    localparam logic [SLOT_W-1:0] K0 = '0;
    localparam logic [SLOT_W-1:0] K1 = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] K2 = SLOT_W'(2);
    localparam logic [SLOT_W-1:0] K3 = SLOT_W'(3);

    logic [MAX_BITS-1:0] shreg, rxsh;
    logic [SLOT_W-1:0]   n2, last, sh_lo, sh_hi, sm_lo, sm_hi;
    logic [7:0]          lsh;
    logic                do_shift, do_samp;

    // Per-format frame length, shift window and sample window in slots.
    always_comb begin
        n2 = SLOT_W'({cfg_q.nbits, 1'b0});
        case (cfg_q.fmt)
            FMT_SPI: begin
                last = n2;            sh_lo = K1; sh_hi = n2 - K3;
                sm_lo = K0;           sm_hi = n2 - K2;
            end
            FMT_CMDRSP: begin
                last = (n2 << 1) + K1; sh_lo = K1; sh_hi = n2 - K3;
                sm_lo = n2 + K2;       sm_hi = n2 << 1;
            end
            default: begin
                last = n2 + K2;       sh_lo = K3; sh_hi = n2 - K1;
                sm_lo = K2;           sm_hi = n2;
            end
        endcase
    end

    assign do_shift = step && slot[0]  && slot >= sh_lo && slot <= sh_hi;
    assign do_samp  = step && !slot[0] && slot >= sm_lo && slot <= sm_hi;
    assign lsh      = 8'(MAX_BITS) - start_cfg.nbits;
    assign tx_bit   = shreg[MAX_BITS-1];

    // Load a word, step through slots, shift data, deliver the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            slot     <= '0;
            cfg_q    <= '0;
            shreg    <= '0;
            rxsh     <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                slot  <= '0;
                cfg_q <= start_cfg;
                shreg <= start_data << lsh;
                rxsh  <= '0;
            end else if (step) begin
                if (slot == last) begin
                    busy     <= 1'b0;
                    slot     <= '0;
                    rx_valid <= 1'b1;
                    rx_data  <= rxsh;
                end else begin
                    slot <= slot + K1;
                end
                if (do_shift) shreg <= shreg << 1;
                if (do_samp)  rxsh  <= {rxsh[MAX_BITS-2:0], rxd};
            end
        end
    end
endmodule

// File: rtl/mfs_pins.sv
// Pin decoder: serial clock, frame/select, data value and pad enable
// from the current slot. Assumes slot never exceeds the frame length.
module mfs_pins
    import mfs_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              busy,
    input  cfg_t              cfg,
    input  logic [SLOT_W-1:0] slot,
    input  logic              first,
    input  logic              tx_bit,
    input  fmt_e              live_fmt,
    input  logic              live_hiz,
    output logic              sclk,
    output logic              frm,
    output logic              txd,
    output logic              oe
);
    localparam logic [SLOT_W-1:0] K1 = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] K2 = SLOT_W'(2);

    logic [SLOT_W-1:0] n2;
    assign n2 = SLOT_W'({cfg.nbits, 1'b0});

    // Decode all four pins for idle and for each framing.
    always_comb begin
        sclk = 1'b0;
        frm  = (live_fmt == FMT_SPI) || (live_fmt == FMT_CMDRSP);
        txd  = 1'b0;
        oe   = !live_hiz;
        if (busy) begin
            case (cfg.fmt)
                FMT_SPI: begin
                    sclk = slot[0];
                    frm  = 1'b0;
                    txd  = (slot == n2) ? cfg.end_lvl : tx_bit;
                    oe   = 1'b1;
                end
                FMT_CMDRSP: begin
                    sclk = slot[0];
                    frm  = 1'b0;
                    txd  = (slot < n2) ? tx_bit : 1'b0;
                    oe   = !cfg.hiz_en || (slot < n2 - K1)
                           || (slot == n2 - K1 && first);
                end
                default: begin
                    sclk = !slot[0];
                    frm  = (slot < K2);
                    txd  = (slot >= K2) ? tx_bit : 1'b0;
                    oe   = !cfg.hiz_en || (slot >= K2 &&
                           (slot <= n2 + K1 || cfg.tail_hiz));
                end
            endcase
        end
    end
endmodule

// File: rtl/mfs_shifter.sv
// Top of the multi-format serial shifter: handshake, length clamp and
// wiring of timer, sequencer and pin decoder.
// Assumes configuration inputs are static while a frame runs.
module mfs_shifter
    import mfs_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int HALF_DIV = 2,
    localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_valid,
    input  logic [MAX_BITS-1:0] tx_data,
    output logic                tx_ready,
    input  logic [1:0]          fmt,
    input  logic [LEN_W-1:0]    word_len,
    input  logic                tx_hiz_en,
    input  logic                last_hiz,
    input  logic                end_level,
    output logic                sclk_o,
    output logic                frm_o,
    output logic                txd_o,
    output logic                txd_oe,
    input  logic                rxd_i,
    output logic                rx_valid,
    output logic [MAX_BITS-1:0] rx_data
);
    localparam int SLOT_W = $clog2(4 * MAX_BITS + 2);

    logic              busy, step, first, start, tx_bit;
    logic [SLOT_W-1:0] slot;
    cfg_t              cfg_in, cfg_q;
    logic [7:0]        nb_eff;

    // Clamp the requested word length into the supported range.
    always_comb begin
        if (word_len < LEN_W'(4))             nb_eff = 8'd4;
        else if (word_len > LEN_W'(MAX_BITS)) nb_eff = 8'(MAX_BITS);
        else                                  nb_eff = 8'(word_len);
    end

    assign cfg_in   = '{fmt: fmt_e'(fmt), nbits: nb_eff, hiz_en: tx_hiz_en,
                        tail_hiz: last_hiz, end_lvl: end_level};
    assign tx_ready = !busy;
    assign start    = tx_valid && !busy;

    mfs_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .step(step), .first(first)
    );

    mfs_seq #(.MAX_BITS(MAX_BITS), .SLOT_W(SLOT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_cfg(cfg_in),
        .start_data(tx_data), .step(step), .rxd(rxd_i), .busy(busy),
        .cfg_q(cfg_q), .slot(slot), .tx_bit(tx_bit),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    mfs_pins #(.SLOT_W(SLOT_W)) u_pins (
        .busy(busy), .cfg(cfg_q), .slot(slot), .first(first),
        .tx_bit(tx_bit), .live_fmt(fmt_e'(fmt)), .live_hiz(tx_hiz_en),
        .sclk(sclk_o), .frm(frm_o), .txd(txd_o), .oe(txd_oe)
    );
endmodule

// File: rtl/mfs_shifter_chk.sv
// Property checker for mfs_shifter, attached with bind.
// Assumes the synchronous active-low reset of the host block.
module mfs_shifter_chk
    import mfs_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic busy,
    input fmt_e cfg_fmt,
    input logic cfg_hiz,
    input logic first,
    input logic sclk,
    input logic frm,
    input logic oe,
    input logic hiz_live,
    input logic rx_valid
);
    // R1: an accepted word blocks further acceptance next cycle.
    assert_accept_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready);

    // R2: the serial clock only moves at a slot boundary.
    assert_sclk_slot_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !first |-> $stable(sclk));

    // R6: with release off and idle, the pad is driven.
    assert_idle_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !hiz_live |-> oe);

    // R7: SPI with release on ties the pad enable to the select.
    assert_spi_select_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cfg_fmt == FMT_SPI && cfg_hiz |-> oe == !frm);

    // R10: the receive strobe follows the end of a frame.
    assert_strobe_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(busy) && !busy);
endmodule

bind mfs_shifter mfs_shifter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .busy(busy), .cfg_fmt(cfg_q.fmt), .cfg_hiz(cfg_q.hiz_en),
    .first(first), .sclk(sclk_o), .frm(frm_o), .oe(txd_oe),
    .hiz_live(tx_hiz_en), .rx_valid(rx_valid)
);

// File: tb/mfs_shifter_bench.sv
`timescale 1ns/1ps
module mfs_shifter_bench;
    localparam int MB = 32;
    localparam int HD = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_valid = 1'b0;
    logic [MB-1:0] tx_data = '0;
    logic          tx_ready;
    logic [1:0]    fmt = 2'd0;
    logic [5:0]    word_len = 6'd8;
    logic          tx_hiz_en = 1'b0;
    logic          last_hiz = 1'b0;
    logic          end_level = 1'b0;
    logic          sclk_o, frm_o, txd_o, txd_oe;
    logic          rxd_i = 1'b0;
    logic          rx_valid;
    logic [MB-1:0] rx_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    localparam logic [1:0] F_PULSE = 2'd0, F_SPI = 2'd1, F_CMD = 2'd2;

    always #4 clk = ~clk;

    mfs_shifter #(.MAX_BITS(MB), .HALF_DIV(HD)) u_mfs_shifter (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .fmt(fmt), .word_len(word_len),
        .tx_hiz_en(tx_hiz_en), .last_hiz(last_hiz), .end_level(end_level),
        .sclk_o(sclk_o), .frm_o(frm_o), .txd_o(txd_o), .txd_oe(txd_oe),
        .rxd_i(rxd_i), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // One whole frame, checked cycle by cycle against the reference rules.
    task automatic run_frame(input logic [1:0] f, input int wl_in, input int n,
                             input bit tte, input bit lp, input bit el,
                             input logic [31:0] d, input logic [31:0] rw,
                             input bit pre, input bit chain,
                             input logic [31:0] nd);
        int len;
        string freq, oreq;
        logic [31:0] mask;
        logic es, ef, et, eo;
        if (!pre) begin
            fmt = f; word_len = 6'(wl_in); tx_hiz_en = tte;
            last_hiz = lp; end_level = el; tx_data = d; tx_valid = 1'b1;
            @(posedge clk); @(negedge clk);
            tx_valid = 1'b0;
        end
        len  = (f == F_SPI) ? 2*n+1 : (f == F_CMD) ? 4*n+2 : 2*n+3;
        freq = (f == F_SPI) ? "R4" : (f == F_CMD) ? "R5" : "R3";
        oreq = !tte ? "R6" : (f == F_SPI) ? "R7" : (f == F_CMD) ? "R8" : "R9";
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
        chk("R1", "tx_ready during frame", {31'b0, tx_ready}, 32'd0);
        for (int s = 0; s < len; s++) begin
            for (int c = 0; c < HD; c++) begin
                if (c == 0) begin
                    rxd_i = s[1];
                    if (f == F_SPI && s%2 == 0 && s < 2*n)
                        rxd_i = rw[n-1-s/2];
                    if (f == F_PULSE && s%2 == 0 && s >= 2 && s <= 2*n)
                        rxd_i = rw[n-1-(s-2)/2];
                    if (f == F_CMD && s%2 == 0 && s >= 2*n+2 && s <= 4*n)
                        rxd_i = rw[n-1-(s-2*n-2)/2];
                end
                if (f == F_SPI) begin
                    es = s[0]; ef = 1'b0;
                    et = (s == 2*n) ? el : d[n-1-s/2];
                    eo = 1'b1;
                end else if (f == F_CMD) begin
                    es = s[0]; ef = 1'b0;
                    et = (s < 2*n) ? d[n-1-s/2] : 1'b0;
                    eo = !tte || s < 2*n-1 || (s == 2*n-1 && c == 0);
                end else begin
                    es = !s[0]; ef = (s < 2);
                    et = (s < 2) ? 1'b0 : (s <= 2*n+1) ? d[n-1-(s-2)/2] : d[0];
                    eo = !tte || (s >= 2 && (s <= 2*n+1 || lp));
                end
                chk("R2", $sformatf("sclk slot %0d", s), {31'b0, sclk_o}, {31'b0, es});
                chk(freq, $sformatf("frm slot %0d", s), {31'b0, frm_o}, {31'b0, ef});
                chk(freq, $sformatf("txd slot %0d", s), {31'b0, txd_o}, {31'b0, et});
                chk(oreq, $sformatf("oe slot %0d c%0d", s, c), {31'b0, txd_oe}, {31'b0, eo});
                @(negedge clk);
            end
        end
        chk("R10", "rx_valid at end", {31'b0, rx_valid}, 32'd1);
        chk("R10", "rx_data", rx_data, rw & mask);
        chk("R1", "tx_ready at end", {31'b0, tx_ready}, 32'd1);
        if (chain) begin
            tx_data = nd; tx_valid = 1'b1;
            @(posedge clk); @(negedge clk);
            tx_valid = 1'b0;
        end else begin
            @(negedge clk);
            chk("R10", "rx_valid one cycle", {31'b0, rx_valid}, 32'd0);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; fmt = F_SPI; tx_hiz_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset tx_ready", {31'b0, tx_ready}, 32'd1);
        chk("R2", "reset sclk", {31'b0, sclk_o}, 32'd0);
        chk("R10", "reset rx_valid", {31'b0, rx_valid}, 32'd0);
        chk("R4", "idle select high", {31'b0, frm_o}, 32'd1);
        chk("R6", "idle oe release off", {31'b0, txd_oe}, 32'd1);
        tx_hiz_en = 1'b1; fmt = F_PULSE;
        @(negedge clk);
        chk("R6", "idle oe release on", {31'b0, txd_oe}, 32'd0);
        chk("R3", "idle frame pin low", {31'b0, frm_o}, 32'd0);
    endtask

    task automatic t_pulse;
        run_frame(F_PULSE, 4, 4, 1, 0, 0, 32'h9, 32'h6, 0, 0, 0);
        run_frame(F_PULSE, 8, 8, 1, 0, 0, 32'hA5, 32'h3C, 0, 0, 0);
        run_frame(F_PULSE, 17, 17, 1, 1, 0, 32'h1_2D4B, 32'h0_F00F, 0, 0, 0);
        run_frame(F_PULSE, 32, 32, 1, 1, 0, 32'hC3A5_96E1, 32'h5A5A_0FF1, 0, 0, 0);
        run_frame(F_PULSE, 8, 8, 0, 1, 0, 32'h81, 32'hFE, 0, 0, 0);
    endtask

    task automatic t_spi;
        run_frame(F_SPI, 4, 4, 1, 0, 1, 32'h6, 32'h9, 0, 0, 0);
        run_frame(F_SPI, 8, 8, 1, 0, 0, 32'h3D, 32'hB2, 0, 0, 0);
        run_frame(F_SPI, 17, 17, 1, 0, 1, 32'h1_0001, 32'h1_FFFE, 0, 0, 0);
        run_frame(F_SPI, 32, 32, 1, 0, 0, 32'hF0E1_D2C3, 32'h1234_5678, 0, 0, 0);
        // R7: last_hiz set in SPI must leave the enable tied to the select.
        run_frame(F_SPI, 8, 8, 1, 1, 1, 32'h55, 32'hAA, 0, 0, 0);
        run_frame(F_SPI, 8, 8, 0, 0, 1, 32'hC6, 32'h39, 0, 0, 0);
    endtask

    task automatic t_cmd;
        run_frame(F_CMD, 4, 4, 1, 0, 0, 32'hB, 32'h5, 0, 0, 0);
        run_frame(F_CMD, 8, 8, 1, 0, 0, 32'hE7, 32'h18, 0, 0, 0);
        run_frame(F_CMD, 17, 17, 1, 1, 0, 32'h1_5555, 32'h0_AAAA, 0, 0, 0);
        run_frame(F_CMD, 32, 32, 1, 0, 0, 32'h8000_0001, 32'hDEAD_BEEF, 0, 0, 0);
        run_frame(F_CMD, 8, 8, 0, 0, 0, 32'h0F, 32'hF0, 0, 0, 0);
    endtask

    // R2: out-of-range lengths are clamped to 4 and to 32.
    task automatic t_clamp;
        run_frame(F_SPI, 2, 4, 1, 0, 0, 32'hFFFF_FFF5, 32'h7, 0, 0, 0);
        chk("R2", "idle after clamped short frame", {31'b0, tx_ready}, 32'd1);
        run_frame(F_PULSE, 63, 32, 1, 0, 0, 32'h0123_4567, 32'h89AB_CDEF, 0, 0, 0);
        chk("R2", "idle after clamped long frame", {31'b0, tx_ready}, 32'd1);
    endtask

    // R1: a word waiting at frame end is taken in the strobe cycle.
    task automatic t_chain;
        run_frame(F_SPI, 8, 8, 1, 0, 1, 32'hC1, 32'h5E, 0, 1, 32'h3A);
        run_frame(F_SPI, 8, 8, 1, 0, 1, 32'h3A, 32'hA7, 1, 0, 0);
    endtask

    initial begin
        t_reset();
        t_pulse();
        t_spi();
        t_cmd();
        t_clamp();
        t_chain();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule